// File: doc/BRIEF.md
# Serial Register Port for a Calendar Clock

This block is the two-wire bus target that gives a host access to an eight-byte register window: seven timekeeping bytes followed by one control byte. It oversamples the bus clock and data lines with the system clock and cleans them up. It recognises start, repeated start and stop conditions, and it answers only to the fixed 7-bit bus address 1101000. After that it keeps a word pointer that both write and read transfers use.

Write transfers load the pointer first and then store each following byte. Read transfers stream bytes out from the pointer. The registers themselves live in the timekeeping logic next to this block. The port hands them a one-cycle write strobe, and it shows them the pointer as a read address with combinational read data coming back. While a host is reading timekeeping bytes, the port raises a busy flag so that the neighbour can hold back its once-per-second update. A supply-fail input forces the port idle and clears the pointer.

Top module: `rtc_bus_port`

## Requirements
- R1: The port acknowledges only the address bytes 0xD0 (write) and 0xD1 (read). Any other address byte gets no acknowledge. The rest of that transfer does not write and does not move the pointer.
- R2: In a write transfer, the first byte after the address loads the pointer from its low 3 bits. Each further byte produces exactly one `reg_wr_en` pulse with the pointer as `reg_wr_addr`. The pointer then advances on that byte's acknowledge clock.
- R3: The port pulls SDA low during the ninth clock after the address byte, after the pointer byte and after every written data byte.
- R4: In a read transfer, the port shifts out the byte at the pointer, MSB first. When the host acknowledges, the pointer advances and the next byte follows.
- R5: When the host does not acknowledge a read byte, the port releases SDA and leaves the pointer unchanged.
- R6: A read that follows a fresh pointer write under a repeated start begins at the new pointer. A read with no pointer write begins at the pointer left by the previous transfer.
- R7: The pointer is 3 bits wide and wraps from 7 to 0, for both writes and reads.
- R8: While `supply_fail` is high, the transfer in progress is dropped, the pointer returns to 0, nothing is acknowledged and nothing is written.
- R9: `rd_busy` is high from the address acknowledge of a read until the host's not-acknowledge or a stop, and only while the pointer is 0 to 6. It is low while the pointer is 7.
- R10: A stop condition returns the port to idle with SDA released. Bytes clocked in after it without a new start are not acknowledged.
- R11: After reset, SDA is released, `rd_busy` is low, no write strobe occurs and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| supply_fail | input | 1 | Supply out of tolerance; aborts and holds the port idle |
| sda_pull_low | output | 1 | High when the pad must pull SDA low |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 3 | Register index for the write |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_addr | output | 3 | Register index currently addressed for reads (the pointer) |
| reg_rd_data | input | 8 | Byte at `reg_rd_addr`, returned combinationally |
| rd_busy | output | 1 | Host is reading timekeeping bytes; defer the clock update |

## Verification
The bench builds the port with its default values: address 0x68, a 3-bit pointer, 8-bit data and two synchronizer stages. With a pointer only 3 bits wide, the wrap from 7 to 0 and the busy exclusion of the control byte at index 7 can be reached in a few bytes, both in a burst write and in a burst read. The host model runs the bus at sixteen system clocks per quarter bit. That is slow enough to cover the synchronizer and vote latency, and it keeps the repeated-start, not-acknowledge and supply-fail sequences short.

// File: rtl/rtc_bus_port_pkg.sv
package rtc_bus_port_pkg;

    // Transfer controller states
    typedef enum logic [3:0] {
        XS_IDLE,
        XS_DEV,
        XS_ACK_DEV,
        XS_PTR,
        XS_ACK_PTR,
        XS_WDATA,
        XS_ACK_WDATA,
        XS_RLOAD,
        XS_RDATA,
        XS_RACK
    } xfer_state_e;

    // Events decoded from the cleaned bus lines
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/rtc_line_filter.sv
module rtc_line_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    import rtc_bus_port_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             taps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            taps_q <= '1;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            taps_q <= {taps_q[1:0], sync_q[SYNC_STAGES-1]};
            clean  <= vote3(taps_q);
        end
    end

    // A vote output can only flip when the taps hold a majority of the new level
    p_vote_follows_r10: assert property (@(posedge clk) disable iff (rst)
        (clean != $past(clean)) |-> ($past(taps_q[1]) == clean || $past(taps_q[0]) == clean));

endmodule

// File: rtl/rtc_bus_events.sv
module rtc_bus_events (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl,
    input  logic                        sda,
    output rtc_bus_port_pkg::bus_evt_t  evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        evt.scl_rise = scl & ~scl_q;
        evt.scl_fall = ~scl & scl_q;
        evt.start    = scl & scl_q & sda_q & ~sda;
        evt.stop     = scl & scl_q & ~sda_q & sda;
        evt.sda      = sda;
    end

endmodule

// File: rtl/rtc_xfer_ctrl.sv
module rtc_xfer_ctrl #(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         PTR_W    = 3,
    parameter int         DATA_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fail,
    input  rtc_bus_port_pkg::bus_evt_t evt,
    output logic                       sda_low,
    output logic                       wr_en,
    output logic [PTR_W-1:0]           wr_addr,
    output logic [DATA_W-1:0]          wr_data,
    output logic [PTR_W-1:0]           rd_addr,
    input  logic [DATA_W-1:0]          rd_data,
    output logic                       busy
);
    import rtc_bus_port_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
    localparam logic [PTR_W-1:0] CTRL_IDX = {PTR_W{1'b1}};

    xfer_state_e       state;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic [PTR_W-1:0]  ptr;
    logic              rw_q;
    logic              host_ack;

    always_ff @(posedge clk) begin
        if (rst || fail) begin
            state    <= XS_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            ptr      <= '0;
            rw_q     <= 1'b0;
            host_ack <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                state  <= XS_DEV;
                bitcnt <= '0;
            end else if (evt.stop) begin
                state <= XS_IDLE;
            end else begin
                unique case (state)
                    XS_DEV, XS_PTR, XS_WDATA: begin
                        if (evt.scl_rise && bitcnt != FULL) begin
                            shreg  <= {shreg[DATA_W-2:0], evt.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall && bitcnt == FULL) begin
                            if (state == XS_DEV) begin
                                if (shreg[DATA_W-1:DATA_W-7] == DEV_ADDR) begin
                                    rw_q  <= shreg[0];
                                    state <= XS_ACK_DEV;
                                end else begin
                                    state <= XS_IDLE;
                                end
                            end else if (state == XS_PTR) begin
                                ptr   <= shreg[PTR_W-1:0];
                                state <= XS_ACK_PTR;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                state   <= XS_ACK_WDATA;
                            end
                        end
                    end
                    XS_ACK_DEV: if (evt.scl_fall) begin
                        bitcnt <= '0;
                        state  <= rw_q ? XS_RLOAD : XS_PTR;
                    end
                    XS_ACK_PTR: if (evt.scl_fall) begin
                        bitcnt <= '0;
                        state  <= XS_WDATA;
                    end
                    XS_ACK_WDATA: if (evt.scl_fall) begin
                        ptr    <= ptr + 1'b1;
                        bitcnt <= '0;
                        state  <= XS_WDATA;
                    end
                    XS_RLOAD: begin
                        shreg  <= rd_data;
                        bitcnt <= '0;
                        state  <= XS_RDATA;
                    end
                    XS_RDATA: if (evt.scl_fall) begin
                        if (bitcnt == LAST) begin
                            state <= XS_RACK;
                        end else begin
                            shreg  <= {shreg[DATA_W-2:0], 1'b1};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    XS_RACK: begin
                        if (evt.scl_rise) host_ack <= ~evt.sda;
                        if (evt.scl_fall) begin
                            if (host_ack) begin
                                ptr   <= ptr + 1'b1;
                                state <= XS_RLOAD;
                            end else begin
                                state <= XS_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        sda_low = (state == XS_ACK_DEV) || (state == XS_ACK_PTR) || (state == XS_ACK_WDATA)
                  || (state == XS_RDATA && !shreg[DATA_W-1]);
        busy    = ((state == XS_ACK_DEV && rw_q) || state == XS_RLOAD ||
                   state == XS_RDATA || state == XS_RACK) && (ptr != CTRL_IDX);
        rd_addr = ptr;
    end

    p_wr_single_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    p_fail_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        fail |=> (!sda_low && !wr_en && !busy));

    p_busy_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wr_en);

    p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(fail) && $past(state) != XS_PTR) |->
        (ptr == $past(ptr) || ptr == PTR_W'($past(ptr) + 1'b1)));

    p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
        (evt.stop && !fail) |=> !sda_low);

endmodule

// File: rtl/rtc_bus_port.sv
module rtc_bus_port #(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         PTR_W       = 3,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              supply_fail,
    output logic              sda_pull_low,
    output logic              reg_wr_en,
    output logic [PTR_W-1:0]  reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [PTR_W-1:0]  reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              rd_busy
);
    import rtc_bus_port_pkg::*;

    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] clean_lines;
    bus_evt_t         evt;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        rtc_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    rtc_bus_events u_evt (
        .clk (clk),
        .rst (rst),
        .scl (clean_lines[0]),
        .sda (clean_lines[1]),
        .evt (evt)
    );

    rtc_xfer_ctrl #(
        .DEV_ADDR (DEV_ADDR),
        .PTR_W    (PTR_W),
        .DATA_W   (DATA_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .fail    (supply_fail),
        .evt     (evt),
        .sda_low (sda_pull_low),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .busy    (rd_busy)
    );

    p_reset_idle_r11: assert property (@(posedge clk)
        $past(rst) |-> (!sda_pull_low && !reg_wr_en && !rd_busy && reg_rd_addr == '0));

endmodule

// File: tb/rtc_bus_port_test.sv
module rtc_bus_port_test;

    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       supply_fail = 1'b0;
    logic       sda_pull_low;
    logic       reg_wr_en;
    logic [2:0] reg_wr_addr;
    logic [7:0] reg_wr_data;
    logic [2:0] reg_rd_addr;
    logic [7:0] reg_rd_data;
    logic       rd_busy;
    logic       sda_line;

    logic [7:0]  regs [8];
    logic [10:0] exp_q [$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    assign sda_line    = sda_m & ~sda_pull_low;
    assign reg_rd_data = regs[reg_rd_addr];

    rtc_bus_port uut (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .supply_fail  (supply_fail),
        .sda_pull_low (sda_pull_low),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_addr  (reg_wr_addr),
        .reg_wr_data  (reg_wr_data),
        .reg_rd_addr  (reg_rd_addr),
        .reg_rd_data  (reg_rd_data),
        .rd_busy      (rd_busy)
    );

    // Register file model owned by the timekeeping neighbour
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) regs[i] <= 8'h00;
        end else if (reg_wr_en) begin
            regs[reg_wr_addr] <= reg_wr_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every write strobe must match the next expected item
    always @(negedge clk) begin
        if (!rst && reg_wr_en) begin
            if (exp_q.size() == 0) begin
                chk(0, "R1/R8 unexpected write", {reg_wr_addr, reg_wr_data}, 0);
            end else begin
                logic [10:0] e;
                e = exp_q.pop_front();
                chk({reg_wr_addr, reg_wr_data} == e, "R2 write item",
                    {reg_wr_addr, reg_wr_data}, e);
            end
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        acked = !sda_line;
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wq(); scl_m = 1'b1; wq();
            b = {b[6:0], sda_line};
            wq(); scl_m = 1'b0;
        end
        wq(); sda_m = give_ack ? 1'b0 : 1'b1; wq();
        scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic push_wr(input logic [2:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit         ak;
        logic [7:0] d;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(!sda_pull_low && !rd_busy, "R11 reset idle", {sda_pull_low, rd_busy}, 0);
        chk(reg_rd_addr == 3'd0, "R11 reset pointer", reg_rd_addr, 0);

        // R2/R3 burst write at 2
        bus_start();
        send_byte(8'hD0, ak); chk(ak, "R3 address ack", ak, 1);
        send_byte(8'h02, ak); chk(ak, "R3 pointer ack", ak, 1);
        push_wr(3'd2, 8'hA1); send_byte(8'hA1, ak); chk(ak, "R3 data ack", ak, 1);
        push_wr(3'd3, 8'hB2); send_byte(8'hB2, ak); chk(ak, "R3 data ack", ak, 1);
        push_wr(3'd4, 8'hC3); send_byte(8'hC3, ak); chk(ak, "R3 data ack", ak, 1);
        bus_stop();
        chk(!sda_pull_low, "R10 released after stop", sda_pull_low, 0);
        chk(reg_rd_addr == 3'd5, "R2 pointer after writes", reg_rd_addr, 5);

        // R7 write wrap 6,7,0
        bus_start();
        send_byte(8'hD0, ak); send_byte(8'h06, ak);
        push_wr(3'd6, 8'h11); send_byte(8'h11, ak);
        push_wr(3'd7, 8'h22); send_byte(8'h22, ak);
        push_wr(3'd0, 8'h33); send_byte(8'h33, ak);
        bus_stop();
        chk(reg_rd_addr == 3'd1, "R7 write pointer wrap", reg_rd_addr, 1);

        // R4/R6 random read via repeated start
        bus_start();
        send_byte(8'hD0, ak); send_byte(8'h02, ak);
        bus_start();
        send_byte(8'hD1, ak); chk(ak, "R1 read address ack", ak, 1);
        chk(rd_busy, "R9 busy during read", rd_busy, 1);
        recv_byte(1, d); chk(d == 8'hA1, "R6 first byte at new pointer", d, 8'hA1);
        recv_byte(1, d); chk(d == 8'hB2, "R4 next byte", d, 8'hB2);
        recv_byte(0, d); chk(d == 8'hC3, "R4 third byte", d, 8'hC3);
        wq();
        chk(!sda_pull_low, "R5 released after nack", sda_pull_low, 0);
        chk(!rd_busy, "R9 busy drops at nack", rd_busy, 0);
        bus_stop();

        // R5/R6 current-address read: pointer held at 4 by the nack
        bus_start();
        send_byte(8'hD1, ak);
        recv_byte(0, d); chk(d == 8'hC3, "R6 current address read", d, 8'hC3);
        bus_stop();

        // R1 foreign address: no ack, no write, pointer unchanged
        bus_start();
        send_byte(8'hA0, ak); chk(!ak, "R1 foreign address not acked", ak, 0);
        send_byte(8'h03, ak); chk(!ak, "R1 following byte not acked", ak, 0);
        send_byte(8'h77, ak);
        bus_stop();
        bus_start();
        send_byte(8'hD1, ak);
        recv_byte(0, d); chk(d == 8'hC3, "R1 pointer kept", d, 8'hC3);
        bus_stop();

        // R10 byte without start after stop
        send_byte(8'hD0, ak); chk(!ak, "R10 no ack without start", ak, 0);
        bus_stop();

        // R9/R7 read at control index, then wrap
        bus_start();
        send_byte(8'hD0, ak); send_byte(8'h07, ak);
        bus_start();
        send_byte(8'hD1, ak);
        chk(!rd_busy, "R9 busy low at index 7", rd_busy, 0);
        recv_byte(1, d); chk(d == 8'h22, "R4 byte at 7", d, 8'h22);
        wq();
        chk(rd_busy, "R9 busy high after wrap to 0", rd_busy, 1);
        recv_byte(0, d); chk(d == 8'h33, "R7 read wrap to 0", d, 8'h33);
        bus_stop();
        chk(!rd_busy, "R9 busy low after stop", rd_busy, 0);

        // R8 supply fail mid transfer
        bus_start();
        send_byte(8'hD0, ak); send_byte(8'h05, ak);
        supply_fail = 1'b1;
        send_byte(8'h99, ak); chk(!ak, "R8 no ack during fail", ak, 0);
        bus_stop();
        bus_start();
        send_byte(8'hD0, ak); chk(!ak, "R8 address ignored during fail", ak, 0);
        send_byte(8'h01, ak); send_byte(8'h55, ak);
        bus_stop();
        chk(reg_rd_addr == 3'd0, "R8 pointer cleared", reg_rd_addr, 0);
        supply_fail = 1'b0;
        wq();
        bus_start();
        send_byte(8'hD1, ak);
        recv_byte(0, d); chk(d == 8'h33, "R8 read from cleared pointer", d, 8'h33);
        bus_stop();

        wq();
        chk(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule